// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block gathers eleven interrupt sources plus a reset request and presents the winner to a processor core as a request flag and a fixed 16-bit vector address. External pins are sampled once per clock. The dedicated edge pin and the power-down pin are edge-triggered. The two dedicated level pins follow the pin. Three general pins can each be switched between edge and level mode. Internal peripheral event pulses are latched as requests.

Pending requests are ANDed with a mask register; power-down is exempt from the mask. A single global enable gates everything except the reset request. For one cycle after every mask write, nothing is presented. Software can set or clear latched requests through a force/clear write.

The core accepts the presented vector with `ack_i` and ends a service with `rti_i`. A status stack records the active services. With nesting enabled, only a strictly higher-priority request can preempt the service in progress. With nesting disabled, nothing is presented until the stack is empty again.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset release, `irq_req_o`=1 with vector 0x0000, regardless of mask, global enable or nesting. Acknowledging it clears it without recording a service.
- R2: Slots in priority order (0 highest), each with its source and vector: 0 `pwd_i` 0x002C, 1 `irq_i[2]` 0x0004, 2 `lvl_i[1]` 0x0008, 3 `lvl_i[0]` 0x000C, 4 `evt_i[0]` 0x0010, 5 `evt_i[1]` 0x0014, 6 `irqe_i` 0x0018, 7 `evt_i[2]` 0x001C, 8 `evt_i[3]` or `irq_i[1]` 0x0020, 9 `evt_i[4]` or `irq_i[0]` 0x0024, 10 `evt_i[5]` 0x0028.
- R3: Mask bit i (1 = enabled) gates slot i, and all mask bits are 0 after reset. A pending request whose mask bit is 0 is not presented. It is presented once the bit is set.
- R4: When several unmasked requests are pending, the slot with the lowest index is presented.
- R5: Power-down (slot 0) ignores mask bit 0. It latches on a rising edge of `pwd_i`, and acknowledging it clears the latch even while the pin stays high.
- R6: In the cycle after a cycle with `mask_we_i`=1, `irq_req_o`=0 (except for the reset request).
- R7: `cfg_edge_i` bit 0 selects the mode of `irq_i[0]`, bit 1 of `irq_i[1]` and bit 2 of `irq_i[2]` (1 = edge, 0 = level, 0 after reset). In level mode the request follows the sampled pin and survives an acknowledge. In edge mode a rising edge latches a request that the acknowledge clears.
- R8: `lvl_i` pins are always level-sensitive. `irqe_i` is always edge-sensitive.
- R9: A write with `fc_we_i` sets the latched requests named in `fc_set_i` and clears those named in `fc_clr_i`, with bit i meaning slot i. Clear wins over set, and bits for the level-only slots 2 and 3 have no effect.
- R10: Global servicing is enabled at reset. `gie_clr_i` blocks all presentation, power-down included, until `gie_set_i`.
- R11: The status stack holds up to 12 active services. With `cfg_nest_i`=1 a request is presented during a service only if its slot index is lower than the slot on top of the stack. With nesting off (the reset value) nothing is presented while the stack is non-empty. `rti_i` pops one level.
- R12: A pin change or event pulse is reflected in `irq_req_o` after the first rising clock edge that samples it, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwd_i | input | 1 | Power-down request pin (edge) |
| irq_i | input | 3 | Configurable pins irq0..irq2 |
| lvl_i | input | 2 | Dedicated level-sensitive pins |
| irqe_i | input | 1 | Dedicated edge-sensitive pin |
| evt_i | input | 6 | Internal event pulses (bit order in R2) |
| mask_we_i | input | 1 | Mask register write strobe |
| mask_i | input | 11 | Mask write data, bit per slot |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_edge_i | input | 3 | Edge/level select for irq_i |
| cfg_nest_i | input | 1 | Nesting enable |
| fc_we_i | input | 1 | Force/clear write strobe |
| fc_set_i | input | 11 | Slots whose latch is set |
| fc_clr_i | input | 11 | Slots whose latch is cleared |
| gie_set_i | input | 1 | Global enable command |
| gie_clr_i | input | 1 | Global disable command |
| ack_i | input | 1 | Core accepts the presented vector |
| rti_i | input | 1 | Core returns from the current service |
| irq_req_o | output | 1 | Request to the core |
| irq_vec_o | output | 16 | Vector address of the presented request |

## Verification
Pin changes and event pulses show up one rising edge after they are driven. A mask write blanks the request for exactly the following cycle, and the unmasked request appears one edge later. Acknowledge, return, force/clear, control and enable writes take effect at the edge that samples them.

The bench drives every input just after a falling edge and samples the outputs at the next falling edge. Each check therefore lands exactly one edge after its stimulus. Expected vectors are queued by the driver and popped by the monitor in the cycle the request is due.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned N_SRC = 11;
  localparam int unsigned SRC_W = $clog2(N_SRC);
  localparam int unsigned VEC_W = 16;
  // slots able to hold a latched request (2 and 3 are level-only)
  localparam logic [N_SRC-1:0] LATCH_SLOTS = 11'b111_1111_0011;

  typedef logic [N_SRC-1:0] src_vec_t;
  typedef logic [SRC_W-1:0] src_idx_t;
  typedef logic [VEC_W-1:0] vec_t;

  function automatic vec_t vec_of(src_idx_t idx);
    vec_t v;
    case (idx)
      4'd0:    v = 16'h002C;
      4'd1:    v = 16'h0004;
      4'd2:    v = 16'h0008;
      4'd3:    v = 16'h000C;
      4'd4:    v = 16'h0010;
      4'd5:    v = 16'h0014;
      4'd6:    v = 16'h0018;
      4'd7:    v = 16'h001C;
      4'd8:    v = 16'h0020;
      4'd9:    v = 16'h0024;
      4'd10:   v = 16'h0028;
      default: v = 16'h0000;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/prio_irq_sense.sv
module prio_irq_sense #(
  parameter int unsigned N = 11,
  parameter logic [N-1:0] LATCH = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] edge_en_i,
  input  logic [N-1:0] lvl_en_i,
  input  logic [N-1:0] fc_set_i,
  input  logic [N-1:0] fc_clr_i,
  input  logic [N-1:0] ack_clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pin_q;
  logic [N-1:0] latch_q;

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic rise;
    logic latch_d;
    assign rise    = edge_en_i[g] & pin_i[g] & ~pin_q[g];
    assign latch_d = (latch_q[g] | rise | set_i[g] | fc_set_i[g])
                     & ~(fc_clr_i[g] | ack_clr_i[g]) & LATCH[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pin_q[g]   <= 1'b0;
        latch_q[g] <= 1'b0;
      end else begin
        pin_q[g]   <= pin_i[g];
        latch_q[g] <= latch_d;
      end
    end

    assign pend_o[g] = latch_q[g] | (lvl_en_i[g] & pin_q[g]);
  end
endmodule

// File: rtl/prio_irq_pick.sv
module prio_irq_pick #(
  parameter int unsigned N  = 11,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/prio_irq_stack.sv
module prio_irq_stack #(
  parameter int unsigned DEPTH = 12,
  parameter int unsigned IW    = 4,
  localparam int unsigned DW   = $clog2(DEPTH + 1),
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [IW-1:0] push_idx_i,
  input  logic          pop_i,
  output logic [DW-1:0] depth_o,
  output logic [IW-1:0] top_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [IW-1:0] mem_q [DEPTH];
  logic [DW-1:0] ptr_q;

  assign empty_o = (ptr_q == '0);
  assign full_o  = (ptr_q == DW'(DEPTH));
  assign depth_o = ptr_q;
  assign top_o   = empty_o ? '0 : mem_q[AW'(ptr_q - DW'(1))];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (push_i && !full_o) begin
      ptr_q <= ptr_q + DW'(1);
    end else if (pop_i && !empty_o) begin
      ptr_q <= ptr_q - DW'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i && !full_o) mem_q[AW'(ptr_q)] <= push_idx_i;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned STACK_DEPTH = 12,
  localparam int unsigned DW = $clog2(STACK_DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwd_i,
  input  logic [2:0]       irq_i,
  input  logic [1:0]       lvl_i,
  input  logic             irqe_i,
  input  logic [5:0]       evt_i,
  input  logic             mask_we_i,
  input  logic [N_SRC-1:0] mask_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_edge_i,
  input  logic             cfg_nest_i,
  input  logic             fc_we_i,
  input  logic [N_SRC-1:0] fc_set_i,
  input  logic [N_SRC-1:0] fc_clr_i,
  input  logic             gie_set_i,
  input  logic             gie_clr_i,
  input  logic             ack_i,
  input  logic             rti_i,
  output logic             irq_req_o,
  output logic [VEC_W-1:0] irq_vec_o
);
  src_vec_t mask_q;
  logic     hold_q;
  logic [2:0] edge_q;
  logic     nest_q;
  logic     gie_q;
  logic     rst_pend_q;

  src_vec_t pin, setv, edge_en, lvl_en, fc_set, fc_clr, ack_clr, pend, elig;
  logic     any;
  src_idx_t win;
  src_idx_t top;
  logic     empty, full;
  logic [DW-1:0] depth;
  logic     nest_ok, ready, take, push, pop;

  // slot wiring, index = priority (0 highest)
  always_comb begin
    pin     = '0;
    setv    = '0;
    edge_en = '0;
    lvl_en  = '0;
    pin[0]  = pwd_i;     edge_en[0] = 1'b1;
    pin[1]  = irq_i[2];  edge_en[1] = edge_q[2]; lvl_en[1] = ~edge_q[2];
    pin[2]  = lvl_i[1];  lvl_en[2]  = 1'b1;
    pin[3]  = lvl_i[0];  lvl_en[3]  = 1'b1;
    setv[4] = evt_i[0];
    setv[5] = evt_i[1];
    pin[6]  = irqe_i;    edge_en[6] = 1'b1;
    setv[7] = evt_i[2];
    pin[8]  = irq_i[1];  edge_en[8] = edge_q[1]; lvl_en[8] = ~edge_q[1]; setv[8] = evt_i[3];
    pin[9]  = irq_i[0];  edge_en[9] = edge_q[0]; lvl_en[9] = ~edge_q[0]; setv[9] = evt_i[4];
    setv[10] = evt_i[5];
  end

  assign fc_set = fc_we_i ? fc_set_i : '0;
  assign fc_clr = fc_we_i ? fc_clr_i : '0;

  prio_irq_sense #(.N(N_SRC), .LATCH(LATCH_SLOTS)) u_sense (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pin_i     (pin),
    .set_i     (setv),
    .edge_en_i (edge_en),
    .lvl_en_i  (lvl_en),
    .fc_set_i  (fc_set),
    .fc_clr_i  (fc_clr),
    .ack_clr_i (ack_clr),
    .pend_o    (pend)
  );

  // power-down bypasses the mask
  assign elig = pend & (mask_q | src_vec_t'(1));

  prio_irq_pick #(.N(N_SRC), .IW(SRC_W)) u_pick (
    .req_i (elig),
    .any_o (any),
    .idx_o (win)
  );

  prio_irq_stack #(.DEPTH(STACK_DEPTH), .IW(SRC_W)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .push_idx_i (win),
    .pop_i      (pop),
    .depth_o    (depth),
    .top_o      (top),
    .empty_o    (empty),
    .full_o     (full)
  );

  assign nest_ok   = empty | (nest_q & (win < top));
  assign ready     = any & gie_q & ~hold_q & ~full & nest_ok;
  assign irq_req_o = rst_pend_q | ready;
  assign irq_vec_o = rst_pend_q ? '0 : vec_of(win);

  assign take    = ack_i & irq_req_o;
  assign push    = take & ~rst_pend_q;
  assign pop     = rti_i & ~push;
  assign ack_clr = push ? (src_vec_t'(1) << win) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q     <= '0;
      hold_q     <= 1'b0;
      edge_q     <= '0;
      nest_q     <= 1'b0;
      gie_q      <= 1'b1;
      rst_pend_q <= 1'b1;
    end else begin
      hold_q <= mask_we_i;
      if (mask_we_i) mask_q <= mask_i;
      if (cfg_we_i) begin
        edge_q <= cfg_edge_i;
        nest_q <= cfg_nest_i;
      end
      if (gie_clr_i)      gie_q <= 1'b0;
      else if (gie_set_i) gie_q <= 1'b1;
      if (take && rst_pend_q) rst_pend_q <= 1'b0;
    end
  end
endmodule

module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
#(
  parameter int unsigned DEPTH = 12,
  localparam int unsigned DW = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mask_we_i,
  input logic             irq_req_o,
  input logic [VEC_W-1:0] irq_vec_o,
  input logic             rst_pend_q,
  input logic             gie_q,
  input logic             nest_q,
  input logic [DW-1:0]    depth,
  input src_vec_t         mask_q,
  input src_idx_t         win
);
  a_r1_reset_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_pend_q |-> (irq_req_o && irq_vec_o == '0));

  a_r6_mask_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mask_we_i) && !rst_pend_q) |-> !irq_req_o);

  a_r10_global_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gie_q && !rst_pend_q) |-> !irq_req_o);

  a_r11_no_nest_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nest_q && depth != '0 && !rst_pend_q) |-> !irq_req_o);

  a_r3_only_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_req_o && !rst_pend_q) |-> (mask_q[win] || win == '0));

  a_r11_depth_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= DW'(DEPTH));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.DEPTH(STACK_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .mask_we_i  (mask_we_i),
  .irq_req_o  (irq_req_o),
  .irq_vec_o  (irq_vec_o),
  .rst_pend_q (rst_pend_q),
  .gie_q      (gie_q),
  .nest_q     (nest_q),
  .depth      (depth),
  .mask_q     (mask_q),
  .win        (win)
);

// File: tb/tb_prio_irq_ctrl.sv
module tb_prio_irq_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pwd_i = 0, irqe_i = 0;
  logic [2:0]  irq_i = '0;
  logic [1:0]  lvl_i = '0;
  logic [5:0]  evt_i = '0;
  logic        mask_we_i = 0, cfg_we_i = 0, cfg_nest_i = 0, fc_we_i = 0;
  logic [10:0] mask_i = '0, fc_set_i = '0, fc_clr_i = '0;
  logic [2:0]  cfg_edge_i = '0;
  logic        gie_set_i = 0, gie_clr_i = 0, ack_i = 0, rti_i = 0;
  logic        irq_req_o;
  logic [15:0] irq_vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];

  prio_irq_ctrl dut (.*);

  always #4 clk_i = ~clk_i;

  task automatic tick();
    @(negedge clk_i);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input string tag);
    chk(irq_req_o == 1'b0, tag, {31'd0, irq_req_o}, 32'd0);
  endtask

  // driver side: queue the vector that is due now
  task automatic expect_vec(input logic [15:0] v);
    exp_q.push_back(v);
  endtask

  // monitor side: pop and compare, optionally accept
  task automatic mon(input string tag, input bit do_ack);
    logic [15:0] e;
    e = exp_q.pop_front();
    chk(irq_req_o === 1'b1 && irq_vec_o === e, tag, {15'd0, irq_req_o, irq_vec_o}, {15'd0, 1'b1, e});
    if (do_ack) begin
      ack_i = 1'b1;
      tick();
      ack_i = 1'b0;
    end
  endtask

  task automatic take(input logic [15:0] v, input string tag);
    expect_vec(v);
    mon(tag, 1'b1);
  endtask

  task automatic ret();
    rti_i = 1'b1; tick(); rti_i = 1'b0;
  endtask

  task automatic pulse_evt(input logic [5:0] e);
    evt_i = e; tick(); evt_i = '0;
  endtask

  task automatic wr_mask(input logic [10:0] m);
    mask_i = m; mask_we_i = 1'b1; tick(); mask_we_i = 1'b0;
  endtask

  task automatic wr_cfg(input logic [2:0] e, input logic n);
    cfg_edge_i = e; cfg_nest_i = n; cfg_we_i = 1'b1; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic wr_fc(input logic [10:0] s, input logic [10:0] c);
    fc_set_i = s; fc_clr_i = c; fc_we_i = 1'b1; tick(); fc_we_i = 1'b0;
    fc_set_i = '0; fc_clr_i = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();
    // R1: reset vector first, ack leaves nothing behind
    take(16'h0000, "R1 reset vector");
    idle("R1 after reset ack");

    // R12 / R5: power-down edge, mask still zero
    pwd_i = 1'b1;
    idle("R12 not before edge");
    tick();
    take(16'h002C, "R5 R12 power-down unmasked");
    ret();
    idle("R5 edge cleared while pin high");
    pwd_i = 1'b0;
    tick();

    // R3 / R6: masked timer, then unmask with holdoff
    pulse_evt(6'b100000);
    idle("R3 masked timer");
    wr_mask(11'b100_0000_0000);
    idle("R6 holdoff cycle");
    tick();
    take(16'h0028, "R3 unmasked timer");
    ret();

    // R4: priority among three
    wr_mask(11'h7FF);
    tick();
    lvl_i[0] = 1'b1;
    pulse_evt(6'b000110);
    lvl_i[0] = 1'b0;
    take(16'h000C, "R4 lvl0 wins");
    idle("R11 no nesting waits");
    ret();
    take(16'h0014, "R4 s0 receive next");
    ret();
    take(16'h001C, "R4 dma last");
    ret();
    idle("R4 all served");

    // R11: nesting enabled
    wr_cfg(3'b000, 1'b1);
    pulse_evt(6'b100000);
    take(16'h0028, "R11 timer base");
    pulse_evt(6'b000001);
    take(16'h0010, "R11 higher preempts");
    pulse_evt(6'b000100);
    idle("R11 lower waits");
    ret();
    take(16'h001C, "R11 dma after return");
    ret();
    ret();
    idle("R11 stack unwound");

    // R7: irq2 level mode
    irq_i[2] = 1'b1;
    tick();
    take(16'h0004, "R7 level irq2");
    idle("R11 same level not re-presented");
    ret();
    irq_i[2] = 1'b0;
    take(16'h0004, "R7 level survives ack");
    ret();
    idle("R7 level dropped");
    // R7: irq2 edge mode
    wr_cfg(3'b100, 1'b1);
    irq_i[2] = 1'b1;
    tick();
    take(16'h0004, "R7 edge irq2");
    ret();
    idle("R7 edge cleared by ack");
    irq_i[2] = 1'b0;

    // R8: dedicated pins
    irqe_i = 1'b1;
    tick();
    take(16'h0018, "R8 edge pin");
    ret();
    idle("R8 edge pin held high");
    irqe_i = 1'b0;
    lvl_i[1] = 1'b1;
    tick();
    take(16'h0008, "R8 level pin");
    ret();
    lvl_i[1] = 1'b0;
    take(16'h0008, "R8 level pin re-presented");
    ret();
    idle("R8 level pin low");

    // R2: remaining vectors
    wr_fc(11'b011_0000_0000, '0);
    take(16'h0020, "R2 slot8 vector");
    ret();
    take(16'h0024, "R2 slot9 vector");
    ret();
    idle("R2 done");

    // R9: force / clear
    wr_fc(11'b100_0000_0000, '0);
    expect_vec(16'h0028);
    mon("R9 forced timer", 1'b0);
    wr_fc('0, 11'b100_0000_0000);
    idle("R9 cleared timer");
    wr_fc(11'b000_1000_0000, 11'b000_1000_0000);
    idle("R9 clear wins");
    wr_fc(11'b000_0000_1000, '0);
    idle("R9 level slot unaffected");

    // R10: global disable
    gie_clr_i = 1'b1; tick(); gie_clr_i = 1'b0;
    wr_fc(11'b100_0000_0000, '0);
    idle("R10 disabled timer");
    pwd_i = 1'b1;
    tick();
    pwd_i = 1'b0;
    idle("R10 disabled power-down");
    gie_set_i = 1'b1; tick(); gie_set_i = 1'b0;
    take(16'h002C, "R10 power-down after enable");
    ret();
    take(16'h0028, "R10 timer after enable");
    ret();
    idle("R10 all served");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule